// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the configuration front end of a video-conversion channel. A host drives three wires: a serial clock, a serial data line and a load strobe. The block shifts in a 6-bit address followed by an 8-bit data word, both most significant bit first. When the host then pulses the load strobe, the word is committed to the addressed register. The register values leave the block on parallel buses that the rest of the channel decodes.

A frame whose address has bit 4 set is a read rather than a write. It fetches the register at the same address with bit 4 cleared and ignores its data byte. The fetched byte is driven out most significant bit first on an output pin that is shared with one bit of conversion data. The next frame can be shifted in while the read word is still leaving.

Some write addresses are strobes and hold no state:
- 0x04 runs a self-timed soft reset that returns every register to its default.
- 0x05 emits a pulse that clears the colour sequencer.
- 0x23 is a broadcast that loads all three colour offset registers.
- 0x2B is a broadcast that loads all three colour gain registers.

All three serial inputs are oversampled into the master clock domain before any logic uses them.

Top module: `cfgp_serial_port`

## Requirements
- R1: Bits are taken on rising serial-clock edges. The 14 most recent bits before a load strobe form the frame: address bits 5..0 first, then data bits 7..0. Extra leading bits are discarded.
- R2: No register changes while bits are only being shifted. A register changes only after a rising edge of the load strobe.
- R3: After reset the setup buses hold these values:

  | Address | Slot | Value |
  |---|---|---|
  | 0x01 | 0 | 0x0F |
  | 0x02 | 1 | 0x23 |
  | 0x03 | 2 | 0x1F |
  | 0x06 | 3 | 0x05 |
  | 0x08 | 4 | 0x00 |
  | 0x09 | 5 | 0x00 |

  The offsets at 0x20, 0x21 and 0x22 (red, green, blue) read 0x80. The gains at 0x28, 0x29 and 0x2A read 0x5C. Slot i of a bus occupies bits [8i+7:8i].
- R4: A frame with address bit 4 set returns the register at that address with bit 4 cleared. Its data byte changes no register.
- R5: A read places bit 7 on the shared pin once the strobe has been taken. Each later falling serial-clock edge advances one bit. After the eighth falling edge the pin carries the conversion data bit again. When no read is active the pin follows the conversion data bit.
- R6: Address 0x07 reads 0x41, and writes to it are ignored.
- R7: Undefined addresses, 0x04, 0x05 and 0x2B read 0x00. Writes to undefined addresses change nothing.
- R8: A write of any data to 0x04 returns all registers to their R3 values. The soft-reset output is high for exactly PULSE_CYCLES master cycles (default 2).
- R9: A write to 0x05 drives the sequencer-clear output high for exactly PULSE_CYCLES master cycles and leaves all registers unchanged.
- R10: A write to 0x23 loads all three offsets, and a write to 0x2B loads all three gains. Reading 0x23 returns the red offset.
- R11: A new frame may be shifted in while a read word is being shifted out. Both the read data and the new frame stay intact.
- R12: The load strobe passes through SYNC_STAGES synchroniser flops. A register therefore keeps its old value one master cycle after the strobe rises, and holds the new value four master cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial clock from the host |
| ser_din_i | input | 1 | Serial data from the host |
| load_strobe_i | input | 1 | Commit strobe, active high |
| conv_dat_i | input | 1 | Conversion data bit that shares the output pin |
| shared_do_o | output | 1 | Read-back data during a read, conversion data otherwise |
| setup_regs_o | output | 48 | Six setup registers, slot order per R3 |
| offset_regs_o | output | 24 | Red, green and blue offsets |
| gain_regs_o | output | 24 | Red, green and blue gains |
| soft_rst_o | output | 1 | Soft-reset pulse |
| colour_seq_clr_o | output | 1 | Colour sequencer clear pulse |

## Verification
Each fault shows up at the ports soon after it occurs:
- A wrong shift or commit state appears on the parallel register buses within four master cycles of the strobe. It also shows when a full sweep reads every address back through the shared pin.
- A faulty read counter or aliasing mux corrupts individual bits on the pin after the next falling serial-clock edge. A faulty counter can also fail to hand the pin back to conversion data after the eighth edge.
- A miscounted strobe timer shows in the number of master cycles that the reset and clear pulses stay high.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
   localparam int ADDR_W   = 6;
   localparam int DATA_W   = 8;
   localparam int N_SETUP  = 6;
   localparam int N_COLOUR = 3;

   typedef logic [ADDR_W-1:0] addr_t;
   typedef logic [DATA_W-1:0] word_t;

   localparam addr_t SETUP_ADDR [N_SETUP] = '{6'h01, 6'h02, 6'h03, 6'h06, 6'h08, 6'h09};
   localparam word_t SETUP_DEF  [N_SETUP] = '{8'h0F, 8'h23, 8'h1F, 8'h05, 8'h00, 8'h00};

   localparam addr_t A_SOFT_RST  = 6'h04;
   localparam addr_t A_SEQ_CLR   = 6'h05;
   localparam addr_t A_REVISION  = 6'h07;
   localparam addr_t A_OFF_BASE  = 6'h20;
   localparam addr_t A_OFF_ALL   = 6'h23;
   localparam addr_t A_GAIN_BASE = 6'h28;
   localparam addr_t A_GAIN_ALL  = 6'h2B;

   localparam word_t REVISION_ID = 8'h41;
   localparam word_t OFF_DEF     = 8'h80;
   localparam word_t GAIN_DEF    = 8'h5C;
endpackage

// File: rtl/cfgp_sync.sv
module cfgp_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o,
   output logic [WIDTH-1:0] prev_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgp_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];
   logic [WIDTH-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
         last_q <= '0;
      end else begin
         stage_q[0] <= d_i;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
         last_q <= stage_q[STAGES-1];
      end
   end

   assign q_o    = stage_q[STAGES-1];
   assign prev_o = last_q;
endmodule

// File: rtl/cfgp_frame_rx.sv
module cfgp_frame_rx
   import cfgp_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  bit_stb_i,
   input  logic  bit_i,
   input  logic  commit_i,
   output logic  cmd_valid_o,
   output addr_t cmd_addr_o,
   output word_t cmd_data_o
);
   localparam int FRAME_W = ADDR_W + DATA_W;

   logic [FRAME_W-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q        <= '0;
         cmd_valid_o <= 1'b0;
         cmd_addr_o  <= '0;
         cmd_data_o  <= '0;
      end else begin
         if (bit_stb_i) sh_q <= {sh_q[FRAME_W-2:0], bit_i};
         cmd_valid_o <= commit_i;
         if (commit_i) begin
            cmd_addr_o <= sh_q[FRAME_W-1:DATA_W];
            cmd_data_o <= sh_q[DATA_W-1:0];
         end
      end
   end

   // A strobe edge yields exactly one command cycle (R2)
   assert_single_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid_o |=> !cmd_valid_o)
      else $error("command valid held more than one cycle");
endmodule

// File: rtl/cfgp_regbank.sv
module cfgp_regbank
   import cfgp_pkg::*;
#(
   parameter int PULSE_CYCLES = 2,
   parameter int RD_BIT       = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cmd_valid_i,
   input  addr_t                      cmd_addr_i,
   input  word_t                      cmd_data_i,
   output logic [N_SETUP*DATA_W-1:0]  setup_o,
   output logic [N_COLOUR*DATA_W-1:0] offset_o,
   output logic [N_COLOUR*DATA_W-1:0] gain_o,
   output logic                       rd_load_o,
   output word_t                      rd_word_o,
   output logic                       soft_rst_o,
   output logic                       seq_clr_o
);
   localparam int PW = $clog2(PULSE_CYCLES + 1);

   generate
      if (PULSE_CYCLES < 1) begin : g_bad_pulse
         $error("cfgp_regbank: PULSE_CYCLES must be at least 1");
      end
      if (RD_BIT < 0 || RD_BIT >= ADDR_W) begin : g_bad_rdbit
         $error("cfgp_regbank: RD_BIT outside the address");
      end else begin : g_map_check
         for (genvar i = 0; i < N_SETUP; i++) begin : g_chk
            if (SETUP_ADDR[i][RD_BIT]) begin : g_alias
               $error("cfgp_regbank: setup address collides with read bit");
            end
         end
      end
   endgenerate

   logic  wr_en, soft_hit, seq_hit, sw_busy;
   addr_t rd_addr;
   logic [PW-1:0] sw_cnt, seq_cnt;
   word_t setup_q [N_SETUP];
   word_t off_q   [N_COLOUR];
   word_t gain_q  [N_COLOUR];
   logic [N_SETUP-1:0]  setup_we;
   logic [N_COLOUR-1:0] off_we, gain_we;

   assign wr_en     = cmd_valid_i & ~cmd_addr_i[RD_BIT];
   assign rd_load_o = cmd_valid_i &  cmd_addr_i[RD_BIT];
   assign rd_addr   = cmd_addr_i & ~(addr_t'(1) << RD_BIT);
   assign soft_hit  = wr_en && (cmd_addr_i == A_SOFT_RST);
   assign seq_hit   = wr_en && (cmd_addr_i == A_SEQ_CLR);
   assign sw_busy   = (sw_cnt != '0);

   generate
      for (genvar i = 0; i < N_SETUP; i++) begin : g_setup_dec
         assign setup_we[i] = wr_en && (cmd_addr_i == SETUP_ADDR[i]);
         assign setup_o[i*DATA_W +: DATA_W] = setup_q[i];
      end
      for (genvar c = 0; c < N_COLOUR; c++) begin : g_colour_dec
         assign off_we[c]  = wr_en && ((cmd_addr_i == A_OFF_BASE + addr_t'(c)) ||
                                       (cmd_addr_i == A_OFF_ALL));
         assign gain_we[c] = wr_en && ((cmd_addr_i == A_GAIN_BASE + addr_t'(c)) ||
                                       (cmd_addr_i == A_GAIN_ALL));
         assign offset_o[c*DATA_W +: DATA_W] = off_q[c];
         assign gain_o[c*DATA_W +: DATA_W]   = gain_q[c];
      end
   endgenerate

   // self-timed strobes
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sw_cnt  <= '0;
         seq_cnt <= '0;
      end else begin
         if (soft_hit)          sw_cnt <= PW'(PULSE_CYCLES);
         else if (sw_cnt != '0) sw_cnt <= sw_cnt - 1'b1;
         if (seq_hit)            seq_cnt <= PW'(PULSE_CYCLES);
         else if (seq_cnt != '0) seq_cnt <= seq_cnt - 1'b1;
      end
   end

   assign soft_rst_o = sw_busy;
   assign seq_clr_o  = (seq_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_SETUP; i++) setup_q[i] <= SETUP_DEF[i];
         for (int c = 0; c < N_COLOUR; c++) begin
            off_q[c]  <= OFF_DEF;
            gain_q[c] <= GAIN_DEF;
         end
      end else if (sw_busy) begin
         for (int i = 0; i < N_SETUP; i++) setup_q[i] <= SETUP_DEF[i];
         for (int c = 0; c < N_COLOUR; c++) begin
            off_q[c]  <= OFF_DEF;
            gain_q[c] <= GAIN_DEF;
         end
      end else begin
         for (int i = 0; i < N_SETUP; i++)
            if (setup_we[i]) setup_q[i] <= cmd_data_i;
         for (int c = 0; c < N_COLOUR; c++) begin
            if (off_we[c])  off_q[c]  <= cmd_data_i;
            if (gain_we[c]) gain_q[c] <= cmd_data_i;
         end
      end
   end

   always_comb begin
      rd_word_o = '0;
      for (int i = 0; i < N_SETUP; i++)
         if (rd_addr == SETUP_ADDR[i]) rd_word_o = setup_q[i];
      for (int c = 0; c < N_COLOUR; c++) begin
         if (rd_addr == A_OFF_BASE + addr_t'(c))  rd_word_o = off_q[c];
         if (rd_addr == A_GAIN_BASE + addr_t'(c)) rd_word_o = gain_q[c];
      end
      if (rd_addr == A_OFF_ALL)  rd_word_o = off_q[0];
      if (rd_addr == A_REVISION) rd_word_o = REVISION_ID;
   end

   // R4: a read frame leaves every register untouched
   assert_read_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_load_o && !sw_busy) |=> ($stable(setup_o) && $stable(offset_o) && $stable(gain_o)))
      else $error("read frame modified a register");

   // R10: gain broadcast leaves the three gains equal
   assert_gain_bcast_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && cmd_addr_i == A_GAIN_ALL && !sw_busy) |=>
         (gain_q[0] == gain_q[1] && gain_q[1] == gain_q[2]))
      else $error("gain broadcast did not reach all colours");

   // R8: when the soft reset ends, defaults are in place
   assert_sw_defaults_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sw_busy) && !$past(cmd_valid_i)) |->
         (setup_q[0] == SETUP_DEF[0] && off_q[1] == OFF_DEF && gain_q[2] == GAIN_DEF))
      else $error("soft reset left non-default state");

   // R9: the sequencer-clear pulse only starts from its strobe address
   assert_seq_pulse_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seq_clr_o) |-> $past(seq_hit))
      else $error("sequencer clear without its strobe");
endmodule

// File: rtl/cfgp_readout.sv
module cfgp_readout #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic              shift_i,
   input  logic              abort_i,
   input  logic              conv_i,
   output logic              od_o,
   output logic              busy_o
);
   localparam int CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
   localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("cfgp_readout: WORD_W must be at least 2");
      end
   endgenerate

   logic [WORD_W-1:0] sh_q;
   logic [CW-1:0]     cnt_q;
   logic              busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (abort_i) begin
         busy_q <= 1'b0;
      end else if (load_i) begin
         sh_q   <= word_i;
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q && shift_i) begin
         if (cnt_q == LAST) begin
            busy_q <= 1'b0;
         end else begin
            sh_q  <= {sh_q[WORD_W-2:0], 1'b0};
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign od_o   = busy_q ? sh_q[WORD_W-1] : conv_i;
   assign busy_o = busy_q;

   // R5: the read ends only on a falling serial edge or a soft reset
   assert_read_end_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_q) |-> $past(shift_i || abort_i))
      else $error("read ended without a falling serial edge");

   // R5: without an edge the read stays active
   assert_read_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !shift_i && !abort_i) |=> busy_q)
      else $error("read dropped while idle");
endmodule

// File: rtl/cfgp_serial_port.sv
module cfgp_serial_port
   import cfgp_pkg::*;
#(
   parameter int SYNC_STAGES  = 2,
   parameter int PULSE_CYCLES = 2,
   parameter int RD_BIT       = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ser_clk_i,
   input  logic                       ser_din_i,
   input  logic                       load_strobe_i,
   input  logic                       conv_dat_i,
   output logic                       shared_do_o,
   output logic [N_SETUP*DATA_W-1:0]  setup_regs_o,
   output logic [N_COLOUR*DATA_W-1:0] offset_regs_o,
   output logic [N_COLOUR*DATA_W-1:0] gain_regs_o,
   output logic                       soft_rst_o,
   output logic                       colour_seq_clr_o
);
   // lane 0: serial clock, lane 1: strobe, lane 2: data
   logic [2:0] sync_q, sync_prev;
   logic       sclk_rise, sclk_fall, strobe_rise;
   logic       unused_din_prev;
   logic       cmd_valid, rd_load, sw_busy, rd_busy;
   addr_t      cmd_addr;
   word_t      cmd_data, rd_word;

   cfgp_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    ({ser_din_i, load_strobe_i, ser_clk_i}),
      .q_o    (sync_q),
      .prev_o (sync_prev)
   );

   assign sclk_rise       =  sync_q[0] & ~sync_prev[0];
   assign sclk_fall       = ~sync_q[0] &  sync_prev[0];
   assign strobe_rise     =  sync_q[1] & ~sync_prev[1];
   assign unused_din_prev =  sync_prev[2];

   cfgp_frame_rx u_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_stb_i   (sclk_rise),
      .bit_i       (sync_q[2]),
      .commit_i    (strobe_rise),
      .cmd_valid_o (cmd_valid),
      .cmd_addr_o  (cmd_addr),
      .cmd_data_o  (cmd_data)
   );

   cfgp_regbank #(.PULSE_CYCLES(PULSE_CYCLES), .RD_BIT(RD_BIT)) u_bank (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid_i (cmd_valid),
      .cmd_addr_i  (cmd_addr),
      .cmd_data_i  (cmd_data),
      .setup_o     (setup_regs_o),
      .offset_o    (offset_regs_o),
      .gain_o      (gain_regs_o),
      .rd_load_o   (rd_load),
      .rd_word_o   (rd_word),
      .soft_rst_o  (sw_busy),
      .seq_clr_o   (colour_seq_clr_o)
   );

   cfgp_readout #(.WORD_W(DATA_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (rd_load),
      .word_i  (rd_word),
      .shift_i (sclk_fall),
      .abort_i (sw_busy),
      .conv_i  (conv_dat_i),
      .od_o    (shared_do_o),
      .busy_o  (rd_busy)
   );

   assign soft_rst_o = sw_busy;

   // R5/R11: a loaded read is active in the next cycle unless reset
   assert_read_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_load && !sw_busy) |=> rd_busy)
      else $error("read load did not start readout");
endmodule

// File: tb/tb_cfgp_serial_port.sv
module tb_cfgp_serial_port;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n, sclk, sdin, sstb, conv;
   logic        sdo, srst, sclr;
   logic [47:0] setup_w;
   logic [23:0] off_w, gain_w;

   cfgp_serial_port dut (
      .clk              (clk),
      .rst_n            (rst_n),
      .ser_clk_i        (sclk),
      .ser_din_i        (sdin),
      .load_strobe_i    (sstb),
      .conv_dat_i       (conv),
      .shared_do_o      (sdo),
      .setup_regs_o     (setup_w),
      .offset_regs_o    (off_w),
      .gain_regs_o      (gain_w),
      .soft_rst_o       (srst),
      .colour_seq_clr_o (sclr)
   );

   int  checks = 0, errors = 0;
   bit  done = 0;
   int  srst_hi = 0, sclr_hi = 0;
   logic obs [14];
   logic [7:0] m_setup [6];
   logic [7:0] m_off [3];
   logic [7:0] m_gain [3];

   always @(posedge clk) begin
      if (srst) srst_hi++;
      if (sclr) sclr_hi++;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int slot_of(input logic [5:0] a);
      case (a)
         6'h01: return 0;
         6'h02: return 1;
         6'h03: return 2;
         6'h06: return 3;
         6'h08: return 4;
         6'h09: return 5;
         default: return -1;
      endcase
   endfunction

   task automatic model_reset();
      m_setup[0] = 8'h0F; m_setup[1] = 8'h23; m_setup[2] = 8'h1F;
      m_setup[3] = 8'h05; m_setup[4] = 8'h00; m_setup[5] = 8'h00;
      for (int c = 0; c < 3; c++) begin
         m_off[c]  = 8'h80;
         m_gain[c] = 8'h5C;
      end
   endtask

   task automatic model_wr(input logic [5:0] a, input logic [7:0] d);
      int s;
      s = slot_of(a);
      if (s >= 0) m_setup[s] = d;
      else if (a >= 6'h20 && a <= 6'h22) m_off[a - 6'h20] = d;
      else if (a == 6'h23) for (int c = 0; c < 3; c++) m_off[c] = d;
      else if (a >= 6'h28 && a <= 6'h2A) m_gain[a - 6'h28] = d;
      else if (a == 6'h2B) for (int c = 0; c < 3; c++) m_gain[c] = d;
      else if (a == 6'h04) model_reset();
   endtask

   function automatic logic [7:0] model_rd(input logic [5:0] a);
      int s;
      s = slot_of(a);
      if (s >= 0) return m_setup[s];
      if (a >= 6'h20 && a <= 6'h22) return m_off[a - 6'h20];
      if (a == 6'h23) return m_off[0];
      if (a >= 6'h28 && a <= 6'h2A) return m_gain[a - 6'h28];
      if (a == 6'h07) return 8'h41;
      return 8'h00;
   endfunction

   task automatic check_outputs(input string tag);
      logic [47:0] es;
      logic [23:0] eo, eg;
      for (int i = 0; i < 6; i++) es[i*8 +: 8] = m_setup[i];
      for (int c = 0; c < 3; c++) begin
         eo[c*8 +: 8] = m_off[c];
         eg[c*8 +: 8] = m_gain[c];
      end
      chk(setup_w == es, {tag, " setup"},  64'(setup_w), 64'(es));
      chk(off_w == eo,   {tag, " offset"}, 64'(off_w),   64'(eo));
      chk(gain_w == eg,  {tag, " gain"},   64'(gain_w),  64'(eg));
   endtask

   task automatic clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_bit(input logic b, input int idx);
      sdin = b;
      clks(2);
      sclk = 1'b1;
      clks(4);
      sclk = 1'b0;
      clks(4);
      obs[idx] = sdo;
   endtask

   task automatic shift_frame(input logic [5:0] a, input logic [7:0] d);
      logic [13:0] f;
      f = {a, d};
      for (int i = 0; i < 14; i++) send_bit(f[13-i], i);
   endtask

   task automatic strobe();
      sstb = 1'b1;
      clks(4);
      sstb = 1'b0;
      clks(6);
   endtask

   task automatic do_read(input logic [5:0] base, output logic [7:0] v);
      logic first;
      logic tail_ok;
      shift_frame(base | 6'h10, 8'hC3);
      strobe();
      first = sdo;
      shift_frame(6'h0B, 8'h3C);
      v = {first, obs[0], obs[1], obs[2], obs[3], obs[4], obs[5], obs[6]};
      tail_ok = 1'b1;
      for (int i = 7; i < 14; i++) if (obs[i] !== conv) tail_ok = 1'b0;
      chk(tail_ok, "R5 pin returns to conversion data", 64'(tail_ok), 64'(1));
   endtask

   task automatic write_reg(input logic [5:0] a, input logic [7:0] d);
      shift_frame(a, d);
      strobe();
      model_wr(a, d);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      logic [5:0] b;
      int s0;
      rst_n = 1'b0; sclk = 1'b0; sdin = 1'b0; sstb = 1'b0; conv = 1'b1;
      clks(5);
      rst_n = 1'b1;
      clks(3);
      model_reset();

      // R3 defaults, idle strobes, pin follows conversion data
      check_outputs("R3 reset");
      chk(srst == 1'b0, "R8 idle soft reset", 64'(srst), 64'(0));
      chk(sclr == 1'b0, "R9 idle clear", 64'(sclr), 64'(0));
      conv = 1'b0; clks(1);
      chk(sdo == 1'b0, "R5 idle pin low", 64'(sdo), 64'(0));
      conv = 1'b1; clks(1);
      chk(sdo == 1'b1, "R5 idle pin high", 64'(sdo), 64'(1));

      // read sweep of every base address at reset: R3 R4 R6 R7
      for (int i = 0; i < 32; i++) begin
         b = {i[4], 1'b0, i[3:0]};
         do_read(b, v);
         chk(v == model_rd(b), "R4 R6 R7 reset read sweep", 64'(v), 64'(model_rd(b)));
      end

      // R1 leading junk bits are discarded
      send_bit(1'b1, 0); send_bit(1'b0, 1); send_bit(1'b1, 2);
      write_reg(6'h21, 8'h3D);
      check_outputs("R1 last fourteen bits");

      // R2 shifting alone commits nothing; R12 strobe latency
      shift_frame(6'h22, 8'h11);
      clks(10);
      check_outputs("R2 no strobe");
      sstb = 1'b1;
      clks(1);
      chk(off_w[23:16] == m_off[2], "R12 old value one cycle after strobe", 64'(off_w[23:16]), 64'(m_off[2]));
      clks(3);
      model_wr(6'h22, 8'h11);
      chk(off_w[23:16] == 8'h11, "R2 R12 committed after four cycles", 64'(off_w[23:16]), 64'(8'h11));
      sstb = 1'b0;
      clks(6);

      // write sweep over all base addresses except the soft reset: R1 R6 R7 R10
      for (int i = 0; i < 32; i++) begin
         b = {i[4], 1'b0, i[3:0]};
         if (b != 6'h04) begin
            write_reg(b, 8'(i * 37 + 11));
            check_outputs("R1 R6 R7 R10 write sweep");
         end
      end
      for (int i = 0; i < 32; i++) begin
         b = {i[4], 1'b0, i[3:0]};
         do_read(b, v);
         chk(v == model_rd(b), "R4 R6 R7 R10 read sweep", 64'(v), 64'(model_rd(b)));
      end
      check_outputs("R4 dummy data ignored");

      // R10 explicit broadcasts
      write_reg(6'h2B, 8'h9E);
      check_outputs("R10 gain broadcast");
      write_reg(6'h23, 8'h47);
      check_outputs("R10 offset broadcast");
      do_read(6'h2B, v);
      chk(v == 8'h00, "R7 R10 gain broadcast reads zero", 64'(v), 64'(0));
      do_read(6'h23, v);
      chk(v == 8'h47, "R10 offset broadcast reads red", 64'(v), 64'(8'h47));

      // R11 overlap: next write shifted while read word leaves
      shift_frame(6'h11, 8'h00);
      strobe();
      v[7] = sdo;
      shift_frame(6'h02, 8'h5A);
      v[6:0] = {obs[0], obs[1], obs[2], obs[3], obs[4], obs[5], obs[6]};
      chk(v == m_setup[0], "R11 read during overlap", 64'(v), 64'(m_setup[0]));
      strobe();
      model_wr(6'h02, 8'h5A);
      check_outputs("R11 overlapped write");

      // R9 sequencer clear pulse
      s0 = sclr_hi;
      write_reg(6'h05, 8'hFF);
      chk(sclr_hi - s0 == 2, "R9 clear pulse length", 64'(sclr_hi - s0), 64'(2));
      check_outputs("R9 registers kept");

      // R8 soft reset
      s0 = srst_hi;
      write_reg(6'h04, 8'h6B);
      chk(srst_hi - s0 == 2, "R8 reset pulse length", 64'(srst_hi - s0), 64'(2));
      check_outputs("R8 defaults restored");
      do_read(6'h2A, v);
      chk(v == 8'h5C, "R8 gain reads default", 64'(v), 64'(8'h5C));

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule